// File: doc/BRIEF.md
# Snapshot-Read 64-bit Tick Counter

A free-running 64-bit up-counter that advances by one on every clock cycle in which the reference tick strobe is high. The tick is nominally a 24 MHz reference pulse that has already been brought into this clock domain. Software reads the count through a narrow 32-bit register port, one word at a time. Reading the live counter word by word could return a torn value, so reads never see it directly.

To take a reading, software writes 1 to the snapshot-request bit in the control register. That bit then reads back as 1 while the capture is in flight. After a fixed delay of two cycles the hardware copies the live count into a shadow register and clears the bit. Software polls until the bit reads 0, then reads the low and high words from the shadow. These two words always belong to one coherent 64-bit value.

The counter never stops during a capture. The shadow changes only when a capture completes.

Top module: `snapcnt_top`

## Requirements
- R1: After reset the snapshot-request bit reads 0, and both shadow words read 0. The live counter starts from parameter INIT_COUNT, whose default is 0.
- R2: The live counter increases by exactly one at each rising clock edge where `tick_i` is 1, and it holds otherwise. It wraps modulo 2^64, so a carry out of bit 31 reaches the high word.
- R3: A write to offset 0xA0 with data bit 1 set, made while no capture is pending, starts a capture. From the next cycle, a read of 0xA0 returns bit 1 = 1 and all other bits 0.
- R4: The request bit clears at the second rising edge after the edge that accepted the request. At that same edge the shadow takes the live count as it stood just before the edge, without any tick sampled at that edge.
- R5: A read of offset 0xA4 returns shadow bits 31:0, and a read of 0xA8 returns shadow bits 63:32. The read data is combinational from `bus_addr_i`.
- R6: The shadow holds its value in every cycle except the cycle of a capture. The live counter keeps counting while a capture is pending and after it completes.
- R7: A write to 0xA0 with data bit 1 clear has no effect. A request written while a capture is pending is ignored and does not restart the delay.
- R8: Writes to 0xA4 and 0xA8 are ignored. A read of any offset other than 0xA0, 0xA4 and 0xA8 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Reference tick strobe, one count per high cycle |
| bus_addr_i | input | 8 | Register byte offset for reads and writes |
| bus_wr_i | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |

## Verification
The two functions that can coincide are a tick and a capture. In the cycle the request bit clears, a tick may be sampled at the same edge that loads the shadow, and R4 requires that tick to be left out of the snapshot. The bench provokes this by holding the tick high across that edge, both in a directed case and over thousands of random cycles. The captured words are judged against a bench model that counts ticks edge by edge. The bench also writes a second request on the edge where the capture completes, and checks that the request is dropped.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 64;
    localparam int REQ_BIT = 1;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'hA0;
    localparam logic [ADDR_W-1:0] OFF_LOW  = 8'hA4;
    localparam logic [ADDR_W-1:0] OFF_HIGH = 8'hA8;
endpackage

// File: rtl/snapcnt_counter.sv
module snapcnt_counter #(
    parameter int             W    = 64,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    output logic [W-1:0] count_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
endmodule

// File: rtl/snapcnt_capture.sv
module snapcnt_capture #(
    parameter int W     = 64,
    parameter int DELAY = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_i,
    input  logic [W-1:0] count_i,
    output logic         busy_o,
    output logic [W-1:0] shadow_o
);
    localparam int                 WT_W    = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [WT_W-1:0]    WT_LAST = WT_W'(DELAY - 1);

    typedef struct packed {
        logic            busy;
        logic [WT_W-1:0] wait_cnt;
        logic [W-1:0]    shadow;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.wait_cnt == WT_LAST) begin
                st_d.shadow   = count_i;
                st_d.busy     = 1'b0;
                st_d.wait_cnt = '0;
            end else begin
                st_d.wait_cnt = st_q.wait_cnt + WT_W'(1);
            end
        end else if (req_i) begin
            st_d.busy     = 1'b1;
            st_d.wait_cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy     <= 1'b0;
            st_q.wait_cnt <= '0;
            st_q.shadow   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = st_q.busy;
    assign shadow_o = st_q.shadow;
endmodule

// File: rtl/snapcnt_regs.sv
module snapcnt_regs
    import snapcnt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              busy_i,
    input  logic [CNT_W-1:0]  shadow_i,
    output logic              req_o,
    output logic [DATA_W-1:0] rdata_o
);
    always_comb begin
        req_o = wr_i && (addr_i == OFF_CTRL) && wdata_i[REQ_BIT];
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFF_CTRL: rdata_o[REQ_BIT] = busy_i;
            OFF_LOW:  rdata_o = shadow_i[DATA_W-1:0];
            OFF_HIGH: rdata_o = shadow_i[CNT_W-1:DATA_W];
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/snapcnt_top.sv
module snapcnt_top
    import snapcnt_pkg::*;
#(
    parameter logic [63:0] INIT_COUNT  = 64'd0,
    parameter int          LATCH_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o
);
    logic [CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0] shadow_val;
    logic             latch_busy;
    logic             snap_req;

    snapcnt_counter #(
        .W    (CNT_W),
        .INIT (INIT_COUNT)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .count_o (live_cnt)
    );

    snapcnt_capture #(
        .W     (CNT_W),
        .DELAY (LATCH_DELAY)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (snap_req),
        .count_i  (live_cnt),
        .busy_o   (latch_busy),
        .shadow_o (shadow_val)
    );

    snapcnt_regs u_regs (
        .addr_i   (bus_addr_i),
        .wr_i     (bus_wr_i),
        .wdata_i  (bus_wdata_i),
        .busy_i   (latch_busy),
        .shadow_i (shadow_val),
        .req_o    (snap_req),
        .rdata_o  (bus_rdata_o)
    );
endmodule

// File: rtl/snapcnt_checker.sv
module snapcnt_checker #(
    parameter int DELAY = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_i,
    input logic [63:0] count,
    input logic        busy,
    input logic [63:0] shadow,
    input logic [7:0]  addr,
    input logic [31:0] rdata
);
    logic [7:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 8'd1;
        end else begin
            run_q <= '0;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> count == $past(count) + 64'd1); // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(count)); // R2
    AST_LATCH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < 8'(DELAY)); // R4
    AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == 8'(DELAY)); // R4
    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> shadow == $past(count)); // R4
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(shadow)); // R6
    AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 8'hA0) |-> rdata == {30'd0, busy, 1'b0}); // R3
endmodule

bind snapcnt_top snapcnt_checker #(
    .DELAY (LATCH_DELAY)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .count  (live_cnt),
    .busy   (latch_busy),
    .shadow (shadow_val),
    .addr   (bus_addr_i),
    .rdata  (bus_rdata_o)
);

// File: tb/snapcnt_top_bench.sv
module snapcnt_top_bench;
    localparam logic [63:0] INIT = 64'h0000_0000_FFFF_FFF0;
    localparam logic [7:0]  A_CTRL = 8'hA0;
    localparam logic [7:0]  A_LOW  = 8'hA4;
    localparam logic [7:0]  A_HIGH = 8'hA8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        wr = 1'b0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench reference model
    logic [63:0] m_cnt;
    logic [63:0] m_shadow;
    logic        m_busy;
    int          m_wait;

    always #4 clk = ~clk;

    snapcnt_top #(.INIT_COUNT(INIT), .LATCH_DELAY(2)) u_snapcnt_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= INIT; m_shadow <= 64'd0; m_busy <= 1'b0; m_wait <= 0;
        end else begin
            if (tick) m_cnt <= m_cnt + 64'd1;
            if (m_busy) begin
                if (m_wait == 1) begin
                    m_shadow <= m_cnt; m_busy <= 1'b0; m_wait <= 0;
                end else begin
                    m_wait <= m_wait + 1;
                end
            end else if (wr && addr == A_CTRL && wdata[1]) begin
                m_busy <= 1'b1; m_wait <= 0;
            end
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            A_CTRL:  return {30'd0, m_busy, 1'b0};
            A_LOW:   return m_shadow[31:0];
            A_HIGH:  return m_shadow[63:32];
            default: return 32'd0;
        endcase
    endfunction

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic peek(input string tag, input logic [7:0] a);
        @(negedge clk);
        addr = a; wr = 1'b0; tick = 1'b0;
        #1;
        check_eq(tag, rdata, exp_read(a));
    endtask

    task automatic put(input logic [7:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        addr = a; wr = 1'b1; wdata = d; tick = tk;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1; wr = 1'b0;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic snap_and_check(input string tag, input logic [63:0] exp);
        put(A_CTRL, 32'h2, 1'b0);
        #1; check_eq({tag, " busy"}, (addr == A_CTRL) ? rdata : 32'hx, 32'h2);
        @(negedge clk);
        #1; check_eq({tag, " still busy"}, rdata, 32'h2);
        @(negedge clk);
        #1; check_eq({tag, " cleared"}, rdata, 32'h0);
        peek({tag, " low"}, A_LOW);
        check_eq({tag, " low abs"}, rdata, exp[31:0]);
        peek({tag, " high"}, A_HIGH);
        check_eq({tag, " high abs"}, rdata, exp[63:32]);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        addr = A_CTRL; #1; check_eq("R1 ctrl in reset", rdata, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        peek("R1 ctrl after reset", A_CTRL);
        check_eq("R1 ctrl zero", rdata, 32'h0);
        peek("R1 low after reset", A_LOW);
        check_eq("R1 low zero", rdata, 32'h0);
        peek("R1 high after reset", A_HIGH);
        check_eq("R1 high zero", rdata, 32'h0);

        // R3 R4 R5: snapshot with no ticks returns the start value
        snap_and_check("R4 R5 idle snapshot", INIT);

        // R2: 20 ticks carry past bit 31
        ticks(20);
        snap_and_check("R2 carry into high word", INIT + 64'd20);

        // R7: write with request bit clear leaves bit at 0
        put(A_CTRL, 32'hFFFF_FFFD, 1'b0);
        #1; check_eq("R7 zero write no effect", rdata, 32'h0);

        // R8: writes to data words ignored, unmapped read zero
        put(A_LOW, 32'h1234_5678, 1'b0);
        peek("R8 low write ignored", A_LOW);
        check_eq("R8 low unchanged", rdata, INIT[31:0] + 32'd20);
        put(A_HIGH, 32'hDEAD_BEEF, 1'b0);
        peek("R8 high write ignored", A_HIGH);
        check_eq("R8 high unchanged", rdata, 32'd1);
        peek("R8 unmapped", 8'h5C);

        // R4 coincidence: tick held high across the capture edge
        @(negedge clk); addr = A_CTRL; wr = 1'b1; wdata = 32'h2; tick = 1'b1;
        @(negedge clk); wr = 1'b0; tick = 1'b1;
        // R7: repeat request while pending, on the capture edge
        @(negedge clk); wr = 1'b1; tick = 1'b1;
        @(negedge clk); wr = 1'b0; tick = 1'b0;
        #1; check_eq("R7 pending request ignored", rdata, 32'h0);
        peek("R4 tick at capture edge low", A_LOW);
        check_eq("R4 tick at capture edge excluded", rdata, INIT[31:0] + 32'd22);

        // R6: counter runs, shadow holds
        ticks(50);
        peek("R6 shadow holds", A_LOW);
        check_eq("R6 shadow holds abs", rdata, INIT[31:0] + 32'd22);
        snap_and_check("R6 counter kept running", INIT + 64'd73);

        // constrained random mix, R3 R5 R7 R8 against model
        for (int i = 0; i < 4000; i++) begin
            int sel;
            @(negedge clk);
            sel = $urandom_range(0, 9);
            tick  = ($urandom_range(0, 9) < 7);
            addr  = (sel < 4) ? A_CTRL : (sel < 6) ? A_LOW : (sel < 8) ? A_HIGH : 8'($urandom);
            wr    = ($urandom_range(0, 9) < 3);
            wdata = $urandom;
            #1;
            if (addr == A_CTRL)
                check_eq("R3 random ctrl", rdata, exp_read(addr));
            else if (addr == A_LOW || addr == A_HIGH)
                check_eq("R5 random data", rdata, exp_read(addr));
            else
                check_eq("R8 random other", rdata, exp_read(addr));
        end
        @(negedge clk); wr = 1'b0; tick = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule